// File: doc/BRIEF.md
# Legacy-Replacement Interrupt Router

This block sits between a multi-channel event timer and a bank of legacy interrupt lines. Each timer channel presents an interrupt level and a programmable destination field. A real-time clock presents one more interrupt level. The router merges all of these onto a vector of interrupt lines. When several sources land on the same line, they are ORed together.

A single software-written mode bit selects legacy replacement. When the bit is set, channel 0 is pinned to line 0 and channel 1 is pinned to line 8. The clock interrupt is masked and a disable signal goes to the legacy interval timer. Channels 2 and up keep their programmed destinations in both modes. The router keeps a record of the clock level at all times. When legacy replacement is switched off again, line 8 therefore resumes with the clock's current level, including any change that happened while the clock was masked.

Inputs are registered once. Each output reflects the inputs and mode write of the previous clock edge.

Top module: `legacyIrqRouter`

## Requirements
- R1: While reset is asserted and after it is released, the mode bit is 0, `pitDisable` is 0, and every line is 0 until a source is active.
- R2: With the mode bit clear, a channel whose level is 1 drives the line numbered by its 5-bit destination field (`timerRoute[c*5 +: 5]` for channel c). This appears one clock edge after the level is presented.
- R3: With the mode bit set, channel 0 drives line 0 and channel 1 drives line 8, and their destination fields have no effect.
- R4: Channels 2 and above use their destination field in both modes.
- R5: The clock input is sampled every cycle in both modes. With the mode bit clear, the sampled level appears on line 8.
- R6: With the mode bit set, the clock level does not reach any line.
- R7: A write of `cfgLegacyWr`=1 while the mode bit is 0 removes the clock from line 8 on the same edge that the mode changes.
- R8: A write of 0 while the mode bit is 1 puts the latest sampled clock level back on line 8 on that edge.
- R9: `pitDisable` is 1 exactly while the mode bit is 1.
- R10: A destination value of 24 or more drives no line.
- R11: A write that leaves the mode bit unchanged changes neither `pitDisable` nor the routing.
- R12: Several sources mapped to one line combine by OR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Mode bit write strobe |
| cfgLegacyWr | input | 1 | Mode bit value to write (1 = legacy replacement) |
| timerIrq | input | 4 | Interrupt level per timer channel |
| timerRoute | input | 20 | Destination field per channel, 5 bits each, channel 0 in bits 4:0 |
| rtcIrq | input | 1 | Real-time clock interrupt level |
| irqLines | output | 24 | Legacy interrupt lines |
| pitDisable | output | 1 | Disable request to the legacy interval timer |

## Verification
The embedded properties check the following on every cycle:
- the clock level is seen on line 8 whenever the mode bit is clear;
- with the mode bit set and no channel active, every line is quiet;
- channel 0 lands on line 0 in legacy mode;
- a mode-changing write takes effect on the next edge;
- a same-value write leaves the mode untouched;
- the disable output tracks the control's copy of the mode bit.

Some behaviours only the scenarios can show:
- the restore of a clock level that changed while masked;
- the OR of colliding destinations;
- out-of-range destinations;
- the per-channel mapping under random destinations and random mode writes.

// File: rtl/legacyIrqRouterPkg.sv
package legacyIrqRouterPkg;

  // Strobes from the mode control to the routing datapath
  typedef struct packed {
    logic setLegacy;   // mode bit goes 0 -> 1 on this edge
    logic clrLegacy;   // mode bit goes 1 -> 0 on this edge
  } modeStrobe_t;

endpackage

// File: rtl/legacyIrqRouterCtrl.sv
module legacyIrqRouterCtrl
  import legacyIrqRouterPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic        cfgLegacyWr,
  output modeStrobe_t strobe,
  output logic        legacyCfg
);

  // Transition detection: only a write that flips the bit yields a strobe
  always_comb begin
    strobe.setLegacy = cfgWrEn && cfgLegacyWr && !legacyCfg;
    strobe.clrLegacy = cfgWrEn && !cfgLegacyWr && legacyCfg;
  end

  always_ff @(posedge clk) begin
    if (!rstN)        legacyCfg <= 1'b0;
    else if (cfgWrEn) legacyCfg <= cfgLegacyWr;
  end

  // R7: an activating strobe leaves the bit set
  assert_set_takes_effect_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setLegacy |=> legacyCfg);

  // R8: a deactivating strobe leaves the bit clear
  assert_clr_takes_effect_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrLegacy |=> !legacyCfg);

  // R11: a same-value write does not move the bit
  assert_same_write_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && (cfgLegacyWr == legacyCfg)) |=> $stable(legacyCfg));

endmodule

// File: rtl/legacyIrqRouterDatapath.sv
module legacyIrqRouterDatapath
  import legacyIrqRouterPkg::*;
#(
  parameter int NUM_TIMERS   = 4,
  parameter int NUM_LINES    = 24,
  parameter int ROUTE_W      = 5,
  parameter int LEGACY_LINE0 = 0,
  parameter int LEGACY_LINE1 = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  modeStrobe_t                   strobe,
  input  logic [NUM_TIMERS-1:0]         timerIrq,
  input  logic [NUM_TIMERS*ROUTE_W-1:0] timerRoute,
  input  logic                          rtcIrq,
  output logic [NUM_LINES-1:0]          irqLines,
  output logic                          legacyQ
);

  localparam logic [ROUTE_W-1:0] PIN0 = ROUTE_W'(LEGACY_LINE0);
  localparam logic [ROUTE_W-1:0] PIN1 = ROUTE_W'(LEGACY_LINE1);

  logic [NUM_TIMERS-1:0]         timerLvlQ;
  logic [NUM_TIMERS*ROUTE_W-1:0] routeQ;
  logic                          rtcLvlQ;
  logic [ROUTE_W-1:0]            dest [NUM_TIMERS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timerLvlQ <= '0;
      routeQ    <= '0;
      rtcLvlQ   <= 1'b0;
      legacyQ   <= 1'b0;
    end else begin
      timerLvlQ <= timerIrq;
      routeQ    <= timerRoute;
      rtcLvlQ   <= rtcIrq;      // recorded in every mode
      if (strobe.setLegacy)      legacyQ <= 1'b1;
      else if (strobe.clrLegacy) legacyQ <= 1'b0;
    end
  end

  // Per-channel destination: the two lowest channels can be pinned
  for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_dest
    if (t == 0) begin : g_pin0
      assign dest[t] = legacyQ ? PIN0 : routeQ[t*ROUTE_W +: ROUTE_W];
    end else if (t == 1) begin : g_pin1
      assign dest[t] = legacyQ ? PIN1 : routeQ[t*ROUTE_W +: ROUTE_W];
    end else begin : g_free
      assign dest[t] = routeQ[t*ROUTE_W +: ROUTE_W];
    end
  end

  // OR-merge onto the line vector; out-of-range destinations match no line
  always_comb begin
    irqLines = '0;
    for (int t = 0; t < NUM_TIMERS; t++) begin
      for (int l = 0; l < NUM_LINES; l++) begin
        if (timerLvlQ[t] && (int'(dest[t]) == l)) irqLines[l] = 1'b1;
      end
    end
    if (!legacyQ && rtcLvlQ) irqLines[LEGACY_LINE1] = 1'b1;
  end

  // R5: clock level passes when the mode is off
  assert_rtc_pass_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!legacyQ && rtcLvlQ) |-> irqLines[LEGACY_LINE1]);

  // R6: in legacy mode with no channel active, nothing (clock included) shows
  assert_rtc_masked_R6: assert property (@(posedge clk) disable iff (!rstN)
    (legacyQ && (timerLvlQ == '0)) |-> (irqLines == '0));

  // R3: channel 0 is pinned to line 0 in legacy mode
  assert_pin_ch0_R3: assert property (@(posedge clk) disable iff (!rstN)
    (legacyQ && timerLvlQ[0]) |-> irqLines[LEGACY_LINE0]);

endmodule

// File: rtl/legacyIrqRouter.sv
module legacyIrqRouter
  import legacyIrqRouterPkg::*;
#(
  parameter int NUM_TIMERS   = 4,
  parameter int NUM_LINES    = 24,
  parameter int LEGACY_LINE0 = 0,
  parameter int LEGACY_LINE1 = 8,
  localparam int ROUTE_W     = $clog2(NUM_LINES)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          cfgWrEn,
  input  logic                          cfgLegacyWr,
  input  logic [NUM_TIMERS-1:0]         timerIrq,
  input  logic [NUM_TIMERS*ROUTE_W-1:0] timerRoute,
  input  logic                          rtcIrq,
  output logic [NUM_LINES-1:0]          irqLines,
  output logic                          pitDisable
);

  modeStrobe_t strobe;
  logic        legacyCfg;
  logic        legacyQ;

  legacyIrqRouterCtrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWrEn    (cfgWrEn),
    .cfgLegacyWr(cfgLegacyWr),
    .strobe     (strobe),
    .legacyCfg  (legacyCfg)
  );

  legacyIrqRouterDatapath #(
    .NUM_TIMERS  (NUM_TIMERS),
    .NUM_LINES   (NUM_LINES),
    .ROUTE_W     (ROUTE_W),
    .LEGACY_LINE0(LEGACY_LINE0),
    .LEGACY_LINE1(LEGACY_LINE1)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .timerIrq  (timerIrq),
    .timerRoute(timerRoute),
    .rtcIrq    (rtcIrq),
    .irqLines  (irqLines),
    .legacyQ   (legacyQ)
  );

  assign pitDisable = legacyQ;

  // R9: the datapath's mode copy agrees with the control's mode bit
  assert_pit_tracks_mode_R9: assert property (@(posedge clk) disable iff (!rstN)
    pitDisable == legacyCfg);

endmodule

// File: tb/test_legacyIrqRouter.sv
`timescale 1ns/1ps
module test_legacyIrqRouter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic        cfgLegacyWr = 1'b0;
  logic [3:0]  timerIrq = '0;
  logic [19:0] timerRoute = '0;
  logic        rtcIrq = 1'b0;
  logic [23:0] irqLines;
  logic        pitDisable;

  int checks = 0;
  int errors = 0;
  logic mLeg = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  legacyIrqRouter i_legacyIrqRouter (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgLegacyWr(cfgLegacyWr),
    .timerIrq(timerIrq), .timerRoute(timerRoute), .rtcIrq(rtcIrq),
    .irqLines(irqLines), .pitDisable(pitDisable)
  );

  function automatic logic [23:0] calcLines(logic leg, logic [3:0] tmr,
                                            logic [19:0] rt, logic rtc);
    logic [23:0] r = '0;
    for (int t = 0; t < 4; t++) begin
      int d = int'(rt[t*5 +: 5]);
      if (leg && t == 0) d = 0;
      if (leg && t == 1) d = 8;
      if (tmr[t] && d < 24) r[d] = 1'b1;
    end
    if (!leg && rtc) r[8] = 1'b1;
    return r;
  endfunction

  function automatic logic [19:0] mkRoute(int r0, int r1, int r2, int r3);
    return {5'(r3), 5'(r2), 5'(r1), 5'(r0)};
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Drive one cycle of stimulus just after an edge; compare just after the next
  task automatic step(input logic wr, input logic wv, input logic [3:0] tmr,
                      input logic [19:0] rt, input logic rtc, input string tag);
    logic [23:0] expL;
    cfgWrEn = wr; cfgLegacyWr = wv; timerIrq = tmr; timerRoute = rt; rtcIrq = rtc;
    if (wr) mLeg = wv;
    expL = calcLines(mLeg, tmr, rt, rtc);
    @(posedge clk); #1;
    checks++;
    if (irqLines !== expL || pitDisable !== mLeg) begin
      errors++;
      $display("FAIL %s: lines=%h pit=%b expected lines=%h pit=%b",
               tag, irqLines, pitDisable, expL, mLeg);
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    summary();
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    #1;
    checks++;  // R1 during reset
    if (irqLines !== '0 || pitDisable !== 1'b0) begin
      errors++;
      $display("FAIL R1: lines=%h pit=%b expected lines=0 pit=0", irqLines, pitDisable);
    end
    rstN = 1'b1;
    step(0, 0, 4'b0000, mkRoute(0, 0, 0, 0), 0, "R1");
    step(0, 0, 4'b0100, mkRoute(1, 2, 5, 7), 0, "R2");
    step(0, 0, 4'b1001, mkRoute(3, 2, 5, 3), 0, "R12");
    step(0, 0, 4'b0100, mkRoute(3, 2, 30, 3), 0, "R10");
    step(0, 0, 4'b0000, mkRoute(3, 2, 30, 3), 1, "R5");
    step(1, 1, 4'b0000, mkRoute(3, 2, 30, 3), 1, "R7");
    step(0, 0, 4'b0011, mkRoute(4, 4, 30, 3), 1, "R3");
    step(0, 0, 4'b1100, mkRoute(4, 4, 8, 12), 1, "R4");
    step(0, 0, 4'b0000, mkRoute(4, 4, 8, 12), 0, "R6");
    step(0, 0, 4'b0000, mkRoute(4, 4, 8, 12), 1, "R6");
    step(1, 1, 4'b0001, mkRoute(4, 4, 8, 12), 1, "R11");
    step(1, 0, 4'b0000, mkRoute(4, 4, 8, 12), 1, "R8");
    step(1, 0, 4'b0010, mkRoute(4, 9, 8, 12), 0, "R11");
    step(1, 1, 4'b0000, mkRoute(4, 9, 8, 12), 0, "R9");
    step(0, 0, 4'b0000, mkRoute(4, 9, 8, 12), 1, "R6");
    step(1, 0, 4'b0000, mkRoute(4, 9, 8, 12), 1, "R8");
    for (int i = 0; i < 400; i++) begin
      logic wr = ($urandom_range(0, 7) == 0);
      step(wr, 1'($urandom), 4'($urandom), 20'($urandom), 1'($urandom), "R4");
    end
    summary();
  end

endmodule